// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is the device-side logic that lets a serial-peripheral flash answer the read-identification command. A host selects the device by pulling chip select low and clocks an 8-bit opcode in on the serial data input, most significant bit first. If the opcode is 9Fh and no program, erase or write cycle is running, the block streams a fixed 40-bit identity on the serial data output. The identity is one manufacturer byte, then two device bytes, then two extended device bytes. The host may stop the stream at any bit by raising chip select.

The block also keeps a power-state flag. When chip select rises after any of the three identification-type opcodes (90h, 9Fh, ABh) has been decoded, the device goes to standby. The next time chip select falls, it returns to active mode. The serial clock, chip select and data input are sampled by a faster system clock, and their edges are found there. The output has a separate enable, which stands for a tri-state pin driver: enable low means high impedance.

Top module: `flashid_responder`

## Requirements
- R1: While cs_n is low, the block samples si on each rising sck edge, most significant bit first. The eighth sample completes the opcode, and an opcode of 9Fh starts the identity stream.
- R2: The identity stream is 40 bits, sent in this order: MFR_ID[7:0], then DEV_ID[15:0], then EXT_ID[15:0]. Each field is sent most significant bit first.
- R3: so_oe stays 0 while the opcode is being shifted in. This includes the moment after the eighth rising edge and before the next falling edge.
- R4: A new output bit appears only on a falling sck edge. The first bit appears on the falling edge that follows the eighth rising edge. so holds its value while sck is high.
- R5: When cs_n goes high, so_oe drops to 0 on the next system clock, whatever the position in the stream.
- R6: If busy is high when the eighth opcode bit arrives, the opcode is not decoded. so_oe stays 0 and standby is not armed.
- R7: When cs_n rises after a decoded 90h, 9Fh or ABh opcode, standby goes to 1.
- R8: When cs_n falls, standby goes to 0 and stays 0 while cs_n stays low.
- R9: Any other complete opcode keeps so_oe at 0 for the whole transaction, and the later rise of cs_n leaves standby at 0.
- R10: After all 40 bits have been sent, the next falling sck edge sets so_oe to 0. so_oe stays 0 for the rest of the transaction.
- R11: A high level on cs_n clears the opcode bit count, so a partial opcode is thrown away. The next transaction decodes from its own first bit.
- R12: After reset, so_oe = 0 and standby = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data input (opcode) |
| busy | input | 1 | High while a program, erase or write cycle runs |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |
| standby | output | 1 | 1 while the device is in standby |

## Verification
The assertions assume three things about the inputs. First, sck, cs_n and si are slow compared with clk, so each level lasts for several system cycles. Second, si is stable when sck rises. Third, busy changes only while cs_n is high, and this is why the busy check can relate a steady busy level to a disabled output. The bench drives every pin on the falling edge of clk. It keeps each serial clock phase four system cycles long, and it changes busy only between transactions. This keeps all stimulus inside these assumptions.

// File: rtl/flashid_pkg.sv
// Package: shared constants and types for the identification responder.
// Assumes 8-bit opcodes and a fixed list of identification-type opcodes.
package flashid_pkg;
    localparam int OPC_W     = 8;
    localparam int N_ID_OPS  = 3;

    localparam logic [OPC_W-1:0] OPC_READ_ID = 8'h9F;
    // All opcodes that arm standby on deselect.
    localparam logic [N_ID_OPS-1:0][OPC_W-1:0] ID_OPS = {8'hAB, 8'h9F, 8'h90};

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND  = 2'd2,
        TX_DONE  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/fid_edge_detect.sv
// Module: finds rising and falling edges of sck and cs_n in the clk domain.
// Assumes: sck and cs_n are already synchronous to clk and each level lasts at
// least two clk cycles. Idle levels are sck low and cs_n high.
module fid_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);
    logic sck_q;
    logic cs_q;

    // Purpose: hold the previous sample of each serial pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Purpose: compare the current sample with the previous one.
    always_comb begin
        sck_rise = sck & ~sck_q;
        sck_fall = ~sck & sck_q;
        cs_rise  = cs_n & ~cs_q;
        cs_fall  = ~cs_n & cs_q;
    end
endmodule

// File: rtl/fid_opcode_rx.sv
// Module: shifts the opcode in on rising sck edges and decodes it.
// Assumes: the caller gives single-cycle sck_rise pulses, and busy does not
// change while cs_n is low. Ignores everything after the eighth bit.
module fid_opcode_rx
    import flashid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck_rise,
    input  logic si,
    input  logic busy,
    output logic op_full,
    output logic op_done,
    output logic read_go,
    output logic id_armed
);
    localparam int CNT_W = $clog2(OPC_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPC_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OPC_W);

    logic [OPC_W-1:0] op_q;
    logic [OPC_W-1:0] op_next;
    logic [CNT_W-1:0] cnt_q;
    logic             next_is_id;

    // Purpose: form the opcode value that includes the bit now on si.
    always_comb begin
        op_next = {op_q[OPC_W-2:0], si};
    end

    // Purpose: match the finished opcode against the identification list.
    always_comb begin
        next_is_id = 1'b0;
        for (int k = 0; k < N_ID_OPS; k++) begin
            if (op_next == ID_OPS[k]) next_is_id = 1'b1;
        end
    end

    // Purpose: shift register, bit count and decode flags, cleared by cs_n high.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            op_q     <= '0;
            cnt_q    <= '0;
            op_done  <= 1'b0;
            read_go  <= 1'b0;
            id_armed <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (sck_rise && (cnt_q != CNT_FULL)) begin
                op_q  <= op_next;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    op_done  <= 1'b1;
                    read_go  <= (op_next == OPC_READ_ID) && !busy;
                    id_armed <= next_is_id && !busy;
                end
            end
        end
    end

    // Purpose: tell the top level that the opcode phase is over.
    always_comb begin
        op_full = (cnt_q == CNT_FULL);
    end

    // R11: a new transaction starts with an empty count.
    assert_count_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cnt_q == '0));
endmodule

// File: rtl/fid_id_shifter.sv
// Module: sends the identity word on falling sck edges, MSB first.
// Assumes: op_done is a one-cycle pulse that comes before the first falling
// edge after the opcode. cs_n high stops the stream and resets it.
module fid_id_shifter
    import flashid_pkg::*;
#(
    parameter int                   ID_BITS = 40,
    parameter logic [ID_BITS-1:0]   ID_WORD = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck_fall,
    input  logic op_done,
    input  logic read_go,
    output logic so,
    output logic so_oe
);
    localparam int IDX_W = $clog2(ID_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(ID_BITS);

    tx_state_t          st_q;
    logic [ID_BITS-1:0] sreg_q;
    logic [IDX_W-1:0]   idx_q;

    // Purpose: stream sequencing and the output driver registers.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            st_q   <= TX_IDLE;
            sreg_q <= '0;
            idx_q  <= '0;
            so     <= 1'b0;
            so_oe  <= 1'b0;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    if (op_done) st_q <= read_go ? TX_ARMED : TX_DONE;
                end
                TX_ARMED: begin
                    if (sck_fall) begin
                        so     <= ID_WORD[ID_BITS-1];
                        sreg_q <= ID_WORD << 1;
                        idx_q  <= IDX_W'(1);
                        so_oe  <= 1'b1;
                        st_q   <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (sck_fall) begin
                        if (idx_q == IDX_END) begin
                            so_oe <= 1'b0;
                            so    <= 1'b0;
                            st_q  <= TX_DONE;
                        end else begin
                            so     <= sreg_q[ID_BITS-1];
                            sreg_q <= sreg_q << 1;
                            idx_q  <= idx_q + 1'b1;
                        end
                    end
                end
                default: begin
                    so_oe <= 1'b0;
                end
            endcase
        end
    end

    // R10: once the stream is complete the driver stays off.
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_DONE) |-> !so_oe);
endmodule

// File: rtl/fid_power_state.sv
// Module: standby/active flag controlled by chip select.
// Assumes: id_armed still holds its value in the cycle where cs_rise is seen.
module fid_power_state (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic id_armed,
    output logic standby
);
    // Purpose: enter standby on deselect after an ID opcode; wake on select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby <= 1'b0;
        end else if (cs_fall) begin
            standby <= 1'b0;
        end else if (cs_rise) begin
            standby <= id_armed;
        end
    end
endmodule

// File: rtl/flashid_responder.sv
// Module: top of the identification responder. Connects edge detection,
// opcode reception, identity streaming and the power-state flag.
// Assumes: serial pins are synchronous to clk and slow compared with it.
// busy does not change while cs_n is low.
module flashid_responder #(
    parameter logic [7:0]  MFR_ID = 8'hA7,
    parameter logic [15:0] DEV_ID = 16'h3C19,
    parameter logic [15:0] EXT_ID = 16'h0D4E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic busy,
    output logic so,
    output logic so_oe,
    output logic standby
);
    localparam int ID_BITS = $bits(MFR_ID) + $bits(DEV_ID) + $bits(EXT_ID);
    localparam logic [ID_BITS-1:0] ID_WORD = {MFR_ID, DEV_ID, EXT_ID};

    logic sck_rise, sck_fall, cs_rise, cs_fall;
    logic op_full, op_done, read_go, id_armed;

    fid_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall)
    );

    fid_opcode_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
        .si(si), .busy(busy), .op_full(op_full), .op_done(op_done),
        .read_go(read_go), .id_armed(id_armed)
    );

    fid_id_shifter #(.ID_BITS(ID_BITS), .ID_WORD(ID_WORD)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
        .op_done(op_done), .read_go(read_go), .so(so), .so_oe(so_oe)
    );

    fid_power_state u_pwr (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .id_armed(id_armed), .standby(standby)
    );

    // R3: no drive before the opcode is complete.
    assert_z_in_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !op_full) |-> !so_oe);

    // R4: output and enable change only on a falling serial clock.
    assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sck_fall) |=> ($stable(so) && $stable(so_oe)));

    // R5: deselect releases the output.
    assert_cs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe);

    // R6: a steady busy level keeps the output released.
    assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && busy && $past(!cs_n && busy)) |-> !so_oe);

    // R8: the device is active while selected.
    assert_active_when_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> !standby);
endmodule

// File: tb/sim_flashid_responder.sv
module sim_flashid_responder;
    localparam logic [7:0]  MFR = 8'hA7;
    localparam logic [15:0] DEV = 16'h3C19;
    localparam logic [15:0] EXT = 16'h0D4E;
    localparam logic [39:0] EXP = {MFR, DEV, EXT};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic busy = 1'b0;
    logic so, so_oe, standby;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flashid_responder #(.MFR_ID(MFR), .DEV_ID(DEV), .EXT_ID(EXT)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .busy(busy), .so(so), .so_oe(so_oe), .standby(standby)
    );

    task automatic chk(input logic ok, input string req, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait4();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse();
        sck = 1'b1; wait4();
        sck = 1'b0; wait4();
    endtask

    task automatic send_op(input logic [7:0] op);
        for (int i = 7; i >= 0; i--) begin
            si = op[i];
            sck = 1'b1; wait4();
            chk(so_oe == 1'b0, "R3 oe during opcode", so_oe, 1'b0);
            sck = 1'b0; wait4();
            if (i > 0) chk(so_oe == 1'b0, "R3 oe between opcode bits", so_oe, 1'b0);
        end
    endtask

    task automatic t_reset();
        chk(so_oe == 1'b0, "R12 reset oe", so_oe, 1'b0);
        chk(standby == 1'b0, "R12 reset standby", standby, 1'b0);
    endtask

    task automatic t_read_full();
        cs_n = 1'b0; wait4();
        chk(standby == 1'b0, "R8 active on select", standby, 1'b0);
        send_op(8'h9F);
        for (int k = 0; k < 40; k++) begin
            chk(so_oe == 1'b1, "R1 oe during stream", so_oe, 1'b1);
            chk(so == EXP[39-k], "R2 stream bit", so, EXP[39-k]);
            if (k < 39) begin
                sck = 1'b1; wait4();
                chk(so == EXP[39-k], "R4 held while sck high", so, EXP[39-k]);
                sck = 1'b0; wait4();
            end
        end
        pulse();
        chk(so_oe == 1'b0, "R10 released after 40 bits", so_oe, 1'b0);
        pulse();
        chk(so_oe == 1'b0, "R10 stays released", so_oe, 1'b0);
        cs_n = 1'b1; wait4();
        chk(standby == 1'b1, "R7 standby after 9Fh", standby, 1'b1);
    endtask

    task automatic t_abort();
        cs_n = 1'b0; wait4();
        chk(standby == 1'b0, "R8 wake on select", standby, 1'b0);
        send_op(8'h9F);
        for (int k = 0; k < 12; k++) pulse();
        chk(so_oe == 1'b1 && so == EXP[27], "R2 mid-stream bit 12", so, EXP[27]);
        cs_n = 1'b1; wait4();
        chk(so_oe == 1'b0, "R5 abort releases", so_oe, 1'b0);
        chk(standby == 1'b1, "R7 standby after abort", standby, 1'b1);
    endtask

    task automatic t_busy();
        busy = 1'b1; wait4();
        cs_n = 1'b0; wait4();
        send_op(8'h9F);
        for (int k = 0; k < 4; k++) begin
            pulse();
            chk(so_oe == 1'b0, "R6 no output when busy", so_oe, 1'b0);
        end
        cs_n = 1'b1; wait4();
        chk(standby == 1'b0, "R6 no standby when busy", standby, 1'b0);
        busy = 1'b0; wait4();
    endtask

    task automatic t_idtype(input logic [7:0] op);
        cs_n = 1'b0; wait4();
        send_op(op);
        pulse();
        chk(so_oe == 1'b0, "R7 no stream for other ID opcode", so_oe, 1'b0);
        cs_n = 1'b1; wait4();
        chk(standby == 1'b1, "R7 standby after ID opcode", standby, 1'b1);
    endtask

    task automatic t_other();
        cs_n = 1'b0; wait4();
        chk(standby == 1'b0, "R8 active again", standby, 1'b0);
        send_op(8'h03);
        for (int k = 0; k < 8; k++) begin
            pulse();
            chk(so_oe == 1'b0, "R9 other opcode silent", so_oe, 1'b0);
        end
        cs_n = 1'b1; wait4();
        chk(standby == 1'b0, "R9 no standby after other opcode", standby, 1'b0);
    endtask

    task automatic t_partial();
        cs_n = 1'b0; wait4();
        si = 1'b0; pulse(); si = 1'b1; pulse(); pulse();
        cs_n = 1'b1; wait4();
        cs_n = 1'b0; wait4();
        send_op(8'h9F);
        for (int k = 0; k < 8; k++) begin
            chk(so_oe == 1'b1 && so == EXP[39-k], "R11 fresh decode after partial", so, EXP[39-k]);
            pulse();
        end
        cs_n = 1'b1; wait4();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_full();
        t_abort();
        t_busy();
        t_idtype(8'h90);
        t_idtype(8'hAB);
        t_other();
        t_partial();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule